// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block holds one byte in a chain of stages. The byte is written into every stage at once through an active-low load control. That load acts without a clock: while the control is low, each stage is forced to the matching parallel input and follows any change on it. Once the load control goes high, the chain shifts by one position on every rising edge of a shift clock. A new bit from the serial input enters the lowest stage, and each stage passes its bit one position up.

The shift clock is the OR of two clock inputs. To shift on one clock alone, hold the other low. Only the top stage can be seen from outside, as a true output and its complement. A byte loaded in parallel therefore leaves the block most significant bit first, one bit per shift edge.

Top module: `piso_shreg`

## Requirements
- R1: While `load_n` is 0, every stage equals the bit of `par_in` at the same index, with no clock edge needed. `out_q` equals `par_in[W-1]` and changes whenever that input bit changes.
- R2: While `load_n` is 0, rising edges on `cp_a` or `cp_b` do not change the contents.
- R3: With `load_n` at 1 and `cp_b` held at 0, a rising edge on `cp_a` shifts the chain. Stage 0 takes `ser_in` and stage i takes the old stage i-1.
- R4: With `load_n` at 1 and `cp_a` held at 0, a rising edge on `cp_b` shifts the chain in the same way as R3.
- R5: A rising edge on one clock input while the other is already high causes no shift, because the combined clock is already high.
- R6: After `load_n` returns to 1, the first shift edge puts the loaded `par_in[W-2]` on `out_q`.
- R7: `out_qn` is always the inverse of `out_q`, including while loading.
- R8: Serial bits reach `out_q` in the order they were entered. The bit entered at shift k appears on `out_q` after shift k+W-1.
- R9: Falling edges of either clock input never shift the chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cp_a | input | 1 | Shift clock input A, ORed with B |
| cp_b | input | 1 | Shift clock input B, ORed with A |
| load_n | input | 1 | Active-low asynchronous parallel load |
| par_in | input | W | Parallel data, bit i goes to stage i |
| ser_in | input | 1 | Serial data into stage 0 |
| out_q | output | 1 | Top stage |
| out_qn | output | 1 | Inverse of the top stage |

## Verification
The loaded byte is chosen so that its top two bits differ. The first shift edge therefore shows whether the second-highest parallel bit really moved up, and not a stale top bit. Parallel inputs are changed while the load is held, and clock edges are applied during the load, which separates continuous following from a one-time capture. Shifts are driven from each clock input alone, from one clock while the other is held high, and on falling edges; this tells a true OR clock apart from either single clock or edge-insensitive logic. A run of alternating and grouped serial bits is then shifted through the whole chain and out again, exposing ordering or off-by-one faults in the stage links.

// File: rtl/piso_pkg.sv
package piso_pkg;
    localparam int unsigned PISO_WIDTH_DEFAULT = 8;
    localparam int unsigned PISO_WIDTH_MIN     = 2;
endpackage

// File: rtl/piso_clk_or.sv
module piso_clk_or (
    input  logic cp_a,
    input  logic cp_b,
    output logic sck
);
    // Either input raises the shared shift clock; a second rising input
    // while the first is high produces no new edge.
    assign sck = cp_a | cp_b;
endmodule

// File: rtl/piso_load_dec.sv
module piso_load_dec #(
    parameter int unsigned W = piso_pkg::PISO_WIDTH_DEFAULT
) (
    input  logic         load_n,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] set_a,
    output logic [W-1:0] clr_a
);
    // Per-stage force lines: exactly one of set/clear is high per stage
    // while loading, so a toggle of par_in produces a fresh rising edge.
    always_comb begin
        for (int i = 0; i < int'(W); i++) begin
            set_a[i] = ~load_n &  par_in[i];
            clr_a[i] = ~load_n & ~par_in[i];
        end
    end
endmodule

// File: rtl/piso_stage.sv
module piso_stage (
    input  logic sck,
    input  logic set_a,
    input  logic clr_a,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic bit_v;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.bit_v = d;
    end

    always_ff @(posedge sck or posedge set_a or posedge clr_a) begin
        if (clr_a) begin
            st_q.bit_v <= 1'b0;
        end else if (set_a) begin
            st_q.bit_v <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.bit_v;
endmodule

// File: rtl/piso_shreg.sv
module piso_shreg #(
    parameter int unsigned W = piso_pkg::PISO_WIDTH_DEFAULT
) (
    input  logic         cp_a,
    input  logic         cp_b,
    input  logic         load_n,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic         out_q,
    output logic         out_qn
);
    localparam int unsigned TOP = W - 1;

    typedef struct packed {
        logic [W-1:0] chain;
    } next_t;

    logic         sck;
    logic [W-1:0] set_a;
    logic [W-1:0] clr_a;
    logic [W-1:0] stage_q;
    next_t        nxt_d;

    initial begin
        if (W < piso_pkg::PISO_WIDTH_MIN) $error("width too small");
    end

    piso_clk_or u_clk (
        .cp_a (cp_a),
        .cp_b (cp_b),
        .sck  (sck)
    );

    piso_load_dec #(.W(W)) u_dec (
        .load_n (load_n),
        .par_in (par_in),
        .set_a  (set_a),
        .clr_a  (clr_a)
    );

    // Next value of every stage on a shift: serial bit at the bottom,
    // each stage takes its lower neighbour.
    always_comb begin
        nxt_d.chain = {stage_q[TOP-1:0], ser_in};
    end

    for (genvar g = 0; g < int'(W); g++) begin : g_stage
        piso_stage u_st (
            .sck   (sck),
            .set_a (set_a[g]),
            .clr_a (clr_a[g]),
            .d     (nxt_d.chain[g]),
            .q     (stage_q[g])
        );
    end

    assign out_q  = stage_q[TOP];
    assign out_qn = ~stage_q[TOP];
endmodule

// File: rtl/piso_shreg_chk.sv
module piso_shreg_chk #(
    parameter int unsigned W = piso_pkg::PISO_WIDTH_DEFAULT
) (
    input logic         cp_a,
    input logic         cp_b,
    input logic         load_n,
    input logic [W-1:0] par_in,
    input logic         ser_in,
    input logic         out_q,
    input logic         out_qn,
    input logic [W-1:0] stage_q
);
    logic       ck;
    logic [1:0] edges_q;

    assign ck = cp_a | cp_b;

    // Edges seen since the last load; a load clears it asynchronously.
    always_ff @(posedge ck or negedge load_n) begin
        if (!load_n) begin
            edges_q <= 2'd0;
        end else if (edges_q != 2'd3) begin
            edges_q <= edges_q + 2'd1;
        end
    end

    assert_load_follow_R1: assert property (@(posedge ck)
        !load_n |-> stage_q == par_in);

    assert_chain_R3: assert property (@(posedge ck) disable iff (!load_n)
        edges_q != 2'd0 |-> stage_q[W-1:1] == $past(stage_q[W-2:0]));

    assert_entry_R3: assert property (@(posedge ck) disable iff (!load_n)
        edges_q != 2'd0 |-> stage_q[0] == $past(ser_in));

    assert_complement_R7: assert property (@(posedge ck)
        out_qn == !out_q);
endmodule

bind piso_shreg piso_shreg_chk #(.W(W)) u_chk (
    .cp_a    (cp_a),
    .cp_b    (cp_b),
    .load_n  (load_n),
    .par_in  (par_in),
    .ser_in  (ser_in),
    .out_q   (out_q),
    .out_qn  (out_qn),
    .stage_q (stage_q)
);

// File: tb/piso_shreg_test.sv
module piso_shreg_test;
    localparam int W = 8;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic         clk = 1'b0;
    logic         cp_a = 1'b0;
    logic         cp_b = 1'b0;
    logic         load_n = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         ser_in = 1'b0;
    logic         out_q;
    logic         out_qn;

    logic [W-1:0] model;
    item_t        sb[$];
    int           checks = 0;
    int           errors = 0;
    int           cycles = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    piso_shreg #(.W(W)) uut (
        .cp_a   (cp_a),
        .cp_b   (cp_b),
        .load_n (load_n),
        .par_in (par_in),
        .ser_in (ser_in),
        .out_q  (out_q),
        .out_qn (out_qn)
    );

    // Monitor: compares queued expectations away from the bench clock edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (out_q !== it.exp) begin
                    errors++;
                    $display("FAIL %s out_q actual %b expected %b", it.tag, out_q, it.exp);
                end
                checks++;
                if (out_qn !== ~it.exp) begin
                    errors++;
                    $display("FAIL R7 (%s) out_qn actual %b expected %b", it.tag, out_qn, ~it.exp);
                end
            end
        end
    end

    task automatic expect_out(input logic e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
        while (sb.size() != 0) @(posedge clk);
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic do_load(input logic [W-1:0] v);
        load_n = 1'b0;
        par_in = v;
        model  = v;
        settle();
    endtask

    task automatic release_load();
        load_n = 1'b1;
        settle();
    endtask

    // One shift on the chosen clock (0: cp_a, 1: cp_b); checks after the
    // rising edge and again after the falling edge.
    task automatic shift(input bit sel, input logic ds, input string tag);
        ser_in = ds;
        settle();
        if (sel) cp_b = 1'b1; else cp_a = 1'b1;
        model = {model[W-2:0], ds};
        settle();
        expect_out(model[W-1], tag);
        if (sel) cp_b = 1'b0; else cp_a = 1'b0;
        settle();
        expect_out(model[W-1], "R9");
    endtask

    initial begin
        logic [15:0] pat;
        settle();
        // R1: load and follow changes while held
        do_load(8'hA5);
        expect_out(1'b1, "R1");
        do_load(8'h25);
        expect_out(1'b0, "R1");
        // R2: clock edges during load are ignored
        cp_a = 1'b1; settle(); expect_out(1'b0, "R2");
        cp_a = 1'b0; cp_b = 1'b1; settle(); expect_out(1'b0, "R2");
        cp_b = 1'b0; settle();
        do_load(8'h43);
        expect_out(1'b0, "R1");
        release_load();
        expect_out(1'b0, "R1");
        // R6: first shift shows par_in[6]
        shift(1'b0, 1'b1, "R6");
        // R3 / R4 shifts
        shift(1'b0, 1'b0, "R3");
        shift(1'b1, 1'b1, "R4");
        shift(1'b1, 1'b0, "R4");
        // R5: cp_a held high, cp_b pulses give no shift
        ser_in = 1'b1;
        settle();
        cp_a = 1'b1;
        model = {model[W-2:0], 1'b1};
        settle();
        expect_out(model[W-1], "R3");
        ser_in = 1'b0;
        settle();
        for (int k = 0; k < 3; k++) begin
            cp_b = 1'b1; settle(); expect_out(model[W-1], "R5");
            cp_b = 1'b0; settle(); expect_out(model[W-1], "R5");
        end
        cp_a = 1'b0;
        settle();
        expect_out(model[W-1], "R9");
        // Drain the remaining stages to expose any hidden shift (R5)
        for (int k = 0; k < W; k++) shift(k[0], 1'b0, "R5");
        // R8: serial order through the whole chain
        do_load(8'h00);
        release_load();
        pat = 16'b1011_0010_1100_1101;
        for (int k = 0; k < 16; k++) shift(k[1], pat[15-k], "R8");
        for (int k = 0; k < W; k++) shift(1'b0, 1'b0, "R8");
        // Load again mid-stream; R7 during load
        do_load(8'hFF);
        expect_out(1'b1, "R7");
        par_in = 8'h7F; model = 8'h7F; settle();
        expect_out(1'b0, "R7");
        release_load();
        shift(1'b1, 1'b0, "R6");
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule